// File: doc/BRIEF.md
# Masked Time Alarm with Sticky Status Flags

This block watches the running time of day, given as BCD seconds, minutes and hours, and sets an alarm flag when the time matches three programmable alarm registers. Each alarm register has its own ignore bit. A partial match, such as "every hour at minute 15, second 30", is set up by ignoring the fields that do not matter.

The block also holds an 8-bit status byte. It has four event flags: watchdog expiry, alarm, power fail and oscillator fail. It also has three control bits: calibration output, write enable and read enable. Reading the status byte clears the watchdog, alarm and power-fail flags. The oscillator-fail flag stays set until software writes a 0 to it, and a reset does not clear it.

The interrupt pin normally carries the OR of the alarm and watchdog flags. When calibration output is on, the pin instead carries a square wave that toggles on every pulse of `cal_tick`. That input pulses at twice the wave frequency, so a 1024 Hz strobe gives the 512 Hz calibration wave.

Top module: `rtc_alarm_flags`

## Requirements
- R1: Alarm register layout. Bit 7 is the ignore bit, bits 6:4 are the BCD tens digit and bits 3:0 are the BCD units digit. The registers sit at `reg_addr` 1 (seconds), 2 (minutes) and 3 (hours). A field with bit 7 = 0 matches only when bits 6:0 equal bits 6:0 of the matching time input.
- R2: A field whose ignore bit is 1 takes no part in the comparison. It counts as matched whatever the time is.
- R3: The alarm flag is set one cycle after a cycle in which `sec_tick` is 1 and every field matches. Matching time alone, without `sec_tick`, never sets it.
- R4: Status byte layout. Bit 7 is watchdog, bit 6 alarm, bit 5 power fail, bit 4 oscillator fail, bit 3 always 0, bit 2 calibration enable, bit 1 write enable, bit 0 read enable. It is always visible on `flags` and is written at `reg_addr` 0.
- R5: A `reg_rd` pulse with `reg_addr` 0 clears bits 7, 6 and 5 one cycle later. It leaves bits 4 and 2:0 unchanged.
- R6: A flag-setting event in the same cycle as a status read wins, and the flag stays 1.
- R7: Writes to the status byte do not change bits 7, 6 and 5.
- R8: The oscillator-fail bit is set by `osc_fail_evt` and cleared only by a status write with bit 4 = 0. A write of 1, a status read and `rst` all leave it unchanged.
- R9: `rst` clears bits 7, 6, 5 and 2:0, clears all alarm registers to 0x00 and brings the calibration wave to 0.
- R10: While the calibration bit is 1, `int_pin` starts at 0 and toggles one cycle after each `cal_tick` pulse.
- R11: While the calibration bit is 0, `int_pin` equals the alarm flag OR the watchdog flag.
- R12: A status write stores bits 2:0 of `reg_wdata` into the calibration, write-enable and read-enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| time_sec | input | 8 | Current seconds, BCD |
| time_min | input | 8 | Current minutes, BCD |
| time_hr | input | 8 | Current hours, BCD |
| sec_tick | input | 1 | One-cycle strobe when the seconds value updates |
| wdt_evt | input | 1 | Watchdog expiry event strobe |
| pwr_fail_evt | input | 1 | Power-fail event strobe |
| osc_fail_evt | input | 1 | Oscillator found stopped at power-up |
| cal_tick | input | 1 | Half-period strobe of the calibration wave |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 to 3 alarm fields |
| reg_wdata | input | 8 | Write data |
| flags | output | 8 | Status byte |
| int_pin | output | 1 | Interrupt or calibration wave output |

## Verification
The alarm comparison is driven with a table of alarm and time pairs:
- A full exact match.
- A one-unit miss in seconds and a one-unit miss in hours.
- Each field ignored in turn with a deliberately wrong time in that field.
- Every field ignored at once.
- A case with the tens and units digits swapped, which catches a digit-order error that an exact match would hide.

Directed cases then cover the following, since each of these shows up only in a specific order of events:
- A matching time with no seconds strobe.
- A read in the same cycle as an event.
- Writes aimed at the read-only flags.
- The oscillator-fail bit surviving reset and reads.
- The calibration wave and its hand-back to normal interrupt use.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int BYTE_W = 8;
    localparam int NFIELD = 3;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_FLAGS = 2'd0,
        ADR_ASEC  = 2'd1,
        ADR_AMIN  = 2'd2,
        ADR_AHR   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       ignore;
        logic [2:0] tens;
        logic [3:0] units;
    } alarm_field_t;

    typedef struct packed {
        logic wdog;
        logic alarm;
        logic pfail;
        logic oscf;
        logic zero;
        logic cal;
        logic wen;
        logic ren;
    } flags_t;

    function automatic logic field_hit(alarm_field_t a, logic [BYTE_W-1:0] t);
        return a.ignore || ({a.tens, a.units} == t[6:0]);
    endfunction
endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int N = NFIELD
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic [N*BYTE_W-1:0]   time_i,
    input  logic                  sec_tick,
    output logic                  alarm_set
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_field
        alarm_field_t fld_q;
        always_ff @(posedge clk) begin
            if (rst)
                fld_q <= '0;
            else if (wr && addr == ADDR_W'(i + 1))
                fld_q <= alarm_field_t'(wdata);
        end
        assign hit[i] = field_hit(fld_q, time_i[i*BYTE_W +: BYTE_W]);
    end

    assign alarm_set = sec_tick && (&hit);
endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_flags,
    input  logic       rd_flags,
    input  logic       wr_osc,
    input  logic [2:0] wr_ctl,
    input  logic       wdt_evt,
    input  logic       alarm_set,
    input  logic       pf_evt,
    input  logic       osc_evt,
    output flags_t     flags_q
);
    // Power-fail survivor: the oscillator bit has no reset term.
    logic oscf_q;

    always_ff @(posedge clk) begin
        if (osc_evt)
            oscf_q <= 1'b1;
        else if (wr_flags && !wr_osc)
            oscf_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q.wdog  <= 1'b0;
            flags_q.alarm <= 1'b0;
            flags_q.pfail <= 1'b0;
            flags_q.cal   <= 1'b0;
            flags_q.wen   <= 1'b0;
            flags_q.ren   <= 1'b0;
        end else begin
            flags_q.wdog  <= wdt_evt   || (flags_q.wdog  && !rd_flags);
            flags_q.alarm <= alarm_set || (flags_q.alarm && !rd_flags);
            flags_q.pfail <= pf_evt    || (flags_q.pfail && !rd_flags);
            if (wr_flags)
                {flags_q.cal, flags_q.wen, flags_q.ren} <= wr_ctl;
        end
    end

    assign flags_q.oscf = oscf_q;
    assign flags_q.zero = 1'b0;

    a_r6_event_wins: assert property (@(posedge clk) disable iff (rst)
        (wdt_evt && rd_flags) |=> flags_q.wdog);
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_flags && !alarm_set) |=> !flags_q.alarm);
    a_r3_alarm_needs_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.alarm) |-> $past(alarm_set));
    a_r7_pfail_not_written: assert property (@(posedge clk) disable iff (rst)
        (wr_flags && !pf_evt && !rd_flags) |=> $stable(flags_q.pfail));
    a_r8_osc_sticky: assert property (@(posedge clk) disable iff (rst)
        (!osc_evt && !(wr_flags && !wr_osc)) |=> $stable(oscf_q));
endmodule

// File: rtl/int_out.sv
module int_out (
    input  logic clk,
    input  logic rst,
    input  logic cal_en,
    input  logic cal_tick,
    input  logic af,
    input  logic wdf,
    output logic int_pin
);
    logic wave_q;

    always_ff @(posedge clk) begin
        if (rst || !cal_en)
            wave_q <= 1'b0;
        else if (cal_tick)
            wave_q <= !wave_q;
    end

    assign int_pin = cal_en ? wave_q : (af || wdf);

    a_r10_wave_toggles: assert property (@(posedge clk) disable iff (rst)
        (cal_en && cal_tick) |=> (!cal_en || wave_q != $past(wave_q)));
    a_r10_wave_holds: assert property (@(posedge clk) disable iff (rst)
        (cal_en && !cal_tick) |=> (!cal_en || $stable(wave_q)));
endmodule

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] time_sec,
    input  logic [BYTE_W-1:0] time_min,
    input  logic [BYTE_W-1:0] time_hr,
    input  logic              sec_tick,
    input  logic              wdt_evt,
    input  logic              pwr_fail_evt,
    input  logic              osc_fail_evt,
    input  logic              cal_tick,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] flags,
    output logic              int_pin
);
    logic   alarm_set;
    logic   sel_flags;
    flags_t flags_q;

    assign sel_flags = (reg_addr == ADR_FLAGS);

    alarm_match #(.N(NFIELD)) u_match (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .time_i   ({time_hr, time_min, time_sec}),
        .sec_tick (sec_tick),
        .alarm_set(alarm_set)
    );

    flag_reg u_flags (
        .clk      (clk),
        .rst      (rst),
        .wr_flags (reg_wr && sel_flags),
        .rd_flags (reg_rd && sel_flags),
        .wr_osc   (reg_wdata[4]),
        .wr_ctl   (reg_wdata[2:0]),
        .wdt_evt  (wdt_evt),
        .alarm_set(alarm_set),
        .pf_evt   (pwr_fail_evt),
        .osc_evt  (osc_fail_evt),
        .flags_q  (flags_q)
    );

    int_out u_int (
        .clk     (clk),
        .rst     (rst),
        .cal_en  (flags_q.cal),
        .cal_tick(cal_tick),
        .af      (flags_q.alarm),
        .wdf     (flags_q.wdog),
        .int_pin (int_pin)
    );

    assign flags = flags_q;

    a_r4_bit3_zero: assert property (@(posedge clk) disable iff (rst)
        flags[3] == 1'b0);
    a_r11_int_follows_flags: assert property (@(posedge clk) disable iff (rst)
        (!flags[2] && (flags[6] || flags[7])) |-> int_pin);
endmodule

// File: tb/sim_rtc_alarm_flags.sv
module sim_rtc_alarm_flags;
    logic clk = 0;
    logic rst = 1;
    logic [7:0] time_sec = 0, time_min = 0, time_hr = 0;
    logic sec_tick = 0, wdt_evt = 0, pwr_fail_evt = 0, osc_fail_evt = 0, cal_tick = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] flags;
    logic int_pin;
    int n_run = 0, n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    rtc_alarm_flags u0 (.*);

    // {alarm sec, alarm min, alarm hr, time sec, time min, time hr, expected}
    localparam logic [55:0] VEC [0:8] = '{
        56'h00_00_00_00_00_00_01,
        56'h30_15_12_30_15_12_01,
        56'h30_15_12_31_15_12_00,
        56'hB0_15_12_59_15_12_01,
        56'h30_95_12_30_44_12_01,
        56'h30_15_92_30_15_23_01,
        56'h30_15_12_30_15_13_00,
        56'h80_80_80_47_33_09_01,
        56'h45_15_92_54_15_07_00
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic flag_read();
        @(negedge clk); reg_rd = 1; reg_addr = 0;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic tick_sec();
        @(negedge clk); sec_tick = 1;
        @(negedge clk); sec_tick = 0;
    endtask

    task automatic tick_cal();
        @(negedge clk); cal_tick = 1;
        @(negedge clk); cal_tick = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        reg_write(0, 8'h00);
        // R9 reset state (all alarm regs 00 as seen via R1 vector 0)
        check("R9 reset flags", flags, 8'h00);
        check("R11 int low after reset", {7'b0, int_pin}, 8'h00);

        foreach (VEC[i]) begin
            reg_write(1, VEC[i][55:48]);
            reg_write(2, VEC[i][47:40]);
            reg_write(3, VEC[i][39:32]);
            flag_read();
            time_sec = VEC[i][31:24];
            time_min = VEC[i][23:16];
            time_hr  = VEC[i][15:8];
            tick_sec();
            check($sformatf("R1/R2/R3 vector %0d alarm flag", i), {7'b0, flags[6]}, VEC[i][7:0]);
            check("R11 int follows alarm", {7'b0, int_pin}, VEC[i][7:0]);
        end

        // R3: matching time without strobe does not set flag
        reg_write(1, 8'h10); reg_write(2, 8'h20); reg_write(3, 8'h05);
        flag_read();
        time_sec = 8'h10; time_min = 8'h20; time_hr = 8'h05;
        repeat (4) @(negedge clk);
        check("R3 no tick no alarm", {7'b0, flags[6]}, 8'h00);
        tick_sec();
        check("R3 tick sets alarm", {7'b0, flags[6]}, 8'h01);

        // R5 read clears event flags, keeps control bits
        @(negedge clk); wdt_evt = 1; pwr_fail_evt = 1;
        @(negedge clk); wdt_evt = 0; pwr_fail_evt = 0;
        reg_write(0, 8'h03);
        check("R4/R12 flag byte layout", flags, 8'hE3);
        flag_read();
        check("R5 read clears 7:5", flags, 8'h03);

        // R6 event wins over read
        @(negedge clk); wdt_evt = 1; reg_rd = 1; reg_addr = 0;
        @(negedge clk); wdt_evt = 0; reg_rd = 0;
        check("R6 event wins", flags, 8'h83);
        flag_read();

        // R7 writes ignored on read-only flags
        reg_write(0, 8'hE8);
        check("R7 readonly flags ignore write", flags, 8'h00);
        @(negedge clk); pwr_fail_evt = 1;
        @(negedge clk); pwr_fail_evt = 0;
        reg_write(0, 8'h00);
        check("R7 write 0 keeps pfail", flags, 8'h20);
        flag_read();

        // R8 oscillator flag
        reg_write(0, 8'h10);
        check("R8 write 1 does not set oscf", flags, 8'h00);
        @(negedge clk); osc_fail_evt = 1;
        @(negedge clk); osc_fail_evt = 0;
        check("R8 oscf set", flags, 8'h10);
        flag_read();
        check("R8 read keeps oscf", flags, 8'h10);
        reg_write(0, 8'h13);
        check("R8/R12 write 1 keeps oscf", flags, 8'h13);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check("R8/R9 reset keeps oscf, clears ctl", flags, 8'h10);
        reg_write(0, 8'h00);
        check("R8 write 0 clears oscf", flags, 8'h00);

        // R10 calibration wave
        reg_write(0, 8'h04);
        check("R10 wave starts low", {7'b0, int_pin}, 8'h00);
        tick_cal();
        check("R10 toggle high", {7'b0, int_pin}, 8'h01);
        repeat (3) @(negedge clk);
        check("R10 holds between ticks", {7'b0, int_pin}, 8'h01);
        tick_cal();
        check("R10 toggle low", {7'b0, int_pin}, 8'h00);
        @(negedge clk); wdt_evt = 1;
        @(negedge clk); wdt_evt = 0;
        check("R10 wave masks watchdog", {7'b0, int_pin}, 8'h00);
        reg_write(0, 8'h00);
        check("R11 int shows watchdog", {7'b0, int_pin}, 8'h01);
        flag_read();
        check("R11 int low after read", {7'b0, int_pin}, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule